// File: doc/BRIEF.md
# Clocked Serial I/O Controller

This block is a three-wire synchronous serial master: a serial clock, a data output and a data input. The host sees four byte-wide registers: a control register, a status register, a transmit buffer and a receive buffer. Every transfer moves one 8-bit word. The block always drives the serial clock itself. The host can run it transmit-only, receive-only or full duplex.

There are two ways to start the next word. In single mode each word needs a fresh trigger once the previous word has finished. Writes to the transmit buffer that arrive while a word is moving are discarded. In continuous mode a transmit word written during a transfer is held and goes out right behind the current one. In continuous receive-only operation the block keeps receiving by itself and raises an overrun flag when the host falls behind. Two single-cycle interrupt pulses are provided. One tells the host it may write the next transmit word, and the other marks the end of each word.

Top module: `csio_top`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, the serial clock is high, the data output is high, and neither interrupt pulse is active.
- R2: The control register is at address 0. Bit 0 is power, bit 1 is transmit enable, bit 2 is receive enable, bit 3 is mode (0 single, 1 continuous) and bit 4 is direction. Bits 3 and 4 keep their value on any write made while power already reads 1. A write made while power reads 0 updates them, including a write that sets power in the same access.
- R3: The serial clock idles high. It is low for CLK_DIV/2 system clocks and then high for CLK_DIV/2 system clocks, once per bit. The busy flag (status bit 0, address 1) stays high for exactly 8*CLK_DIV system clocks per word.
- R4: With direction 0 the most significant bit goes out first. Data out changes as the serial clock falls. Data in is sampled as it rises. The received word is read at address 3.
- R5: With direction 1 the least significant bit goes out and comes in first.
- R6: In single mode a reception-complete pulse occurs for every finished word and the transmit-enable pulse never occurs.
- R7: In single mode a transmit-buffer write (address 2) while busy is discarded: no second word is sent, and busy falls after the first word.
- R8: In single receive-only mode (transmit enable 0, receive enable 1) a receive-buffer read while idle starts one word. A read while busy starts nothing further.
- R9: In continuous mode with transmit enabled, a transmit-buffer write while busy is queued and sent with no idle clock between words. The transmit-enable pulse occurs each time a word is loaded into the shifter.
- R10: In continuous receive-only mode a new word starts right after each reception-complete pulse, whether or not the receive buffer has been read.
- R11: Status bit 1 (overrun) is set when a word completes while the previous received word is unread. It stays set until the host writes 1 to status bit 1.
- R12: Writing power to 0 returns the block to idle (busy low, serial clock high) one clock later. The other control bits and the overrun flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (side effects on the receive buffer) |
| addr | input | 2 | Register address |
| wdata | input | WORD_W | Host write data |
| rdata | output | WORD_W | Register read data, combinational from addr |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out, high when not transmitting |
| sdi | input | 1 | Serial data in |
| irq_tx | output | 1 | Transmit-enable pulse (continuous mode only) |
| irq_rx | output | 1 | Reception-complete pulse |

## Verification
The bench builds the block with WORD_W=8 and CLK_DIV=4, so one word takes 32 system clocks. Back-to-back continuous words, a stream of three automatic receptions that ends in overrun, and power-down in the middle of a stream all fit within a few hundred cycles. The divider of 4 gives two clocks in each serial-clock phase. That leaves room to check the exact busy length, the number of rising edges per word, and that data is stable at the sampling edge.

// File: rtl/csio_pkg.sv
package csio_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_TXB  = 2'd2,
      REG_RXB  = 2'd3
   } csio_addr_e;

   // packed: pwr is bit 0, lsb_first is bit 4
   typedef struct packed {
      logic lsb_first;
      logic cont;
      logic rx_en;
      logic tx_en;
      logic pwr;
   } csio_ctrl_t;

   localparam int CTRL_W = $bits(csio_ctrl_t);

   localparam int STAT_BUSY = 0;
   localparam int STAT_OVR  = 1;

endpackage

// File: rtl/csio_ctrl_reg.sv
module csio_ctrl_reg
   import csio_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  csio_ctrl_t wval,
   output csio_ctrl_t ctrl
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr) begin
         ctrl.pwr   <= wval.pwr;
         ctrl.tx_en <= wval.tx_en;
         ctrl.rx_en <= wval.rx_en;
         // framing bits are frozen while the block is powered
         if (!ctrl.pwr) begin
            ctrl.cont      <= wval.cont;
            ctrl.lsb_first <= wval.lsb_first;
         end
      end
   end

endmodule

// File: rtl/csio_bit_timer.sv
module csio_bit_timer #(
   parameter int WORD_W  = 8,
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic load,
   output logic busy,
   output logic sclk,
   output logic sample_stb,
   output logic shift_stb,
   output logic done
);

   localparam int PH_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam int BIT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam int HALF  = CLK_DIV / 2;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("csio_bit_timer: CLK_DIV must be even and at least 2");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("csio_bit_timer: WORD_W must be at least 2");
      end
   endgenerate

   logic [PH_W-1:0]  phase;
   logic [BIT_W-1:0] bitn;
   logic             last_phase;
   logic             last_bit;

   assign last_phase = (phase == PH_W'(CLK_DIV - 1));
   assign last_bit   = (bitn == BIT_W'(WORD_W - 1));

   assign done       = busy && last_phase && last_bit;
   assign shift_stb  = busy && last_phase && !last_bit;
   assign sample_stb = busy && (phase == PH_W'(HALF - 1));
   assign sclk       = !busy || (phase >= PH_W'(HALF));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         busy  <= 1'b0;
         phase <= '0;
         bitn  <= '0;
      end else if (load) begin
         busy  <= 1'b1;
         phase <= '0;
         bitn  <= '0;
      end else if (busy) begin
         if (last_phase) begin
            phase <= '0;
            if (last_bit) begin
               busy <= 1'b0;
            end else begin
               bitn <= bitn + 1'b1;
            end
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

endmodule

// File: rtl/csio_shifter.sv
module csio_shifter #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [WORD_W-1:0] load_data,
   input  logic              lsb_first,
   input  logic              shift_stb,
   input  logic              sample_stb,
   input  logic              sdi,
   output logic              sdo_bit,
   output logic [WORD_W-1:0] rx_word
);

   logic [WORD_W-1:0] tx_sh;

   assign sdo_bit = lsb_first ? tx_sh[0] : tx_sh[WORD_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         tx_sh   <= '1;
         rx_word <= '0;
      end else begin
         if (load) begin
            tx_sh <= load_data;
         end else if (shift_stb) begin
            tx_sh <= lsb_first ? {1'b1, tx_sh[WORD_W-1:1]}
                               : {tx_sh[WORD_W-2:0], 1'b1};
         end
         if (load) begin
            rx_word <= '0;
         end else if (sample_stb) begin
            rx_word <= lsb_first ? {sdi, rx_word[WORD_W-1:1]}
                                 : {rx_word[WORD_W-2:0], sdi};
         end
      end
   end

endmodule

// File: rtl/csio_top.sv
module csio_top
   import csio_pkg::*;
#(
   parameter int WORD_W  = 8,
   parameter int CLK_DIV = 4,
   parameter int ADDR_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic              sclk,
   output logic              sdo,
   input  logic              sdi,
   output logic              irq_tx,
   output logic              irq_rx
);

   generate
      if (WORD_W < CTRL_W) begin : g_bad_width
         $error("csio_top: WORD_W must hold the control register");
      end
      if (ADDR_W != 2) begin : g_bad_addr
         $error("csio_top: ADDR_W must be 2");
      end
   endgenerate

   csio_ctrl_t        ctrl;
   logic              wr_ctl, wr_stat, wr_tx, rd_rx;
   logic              busy, sample_stb, shift_stb, done;
   logic              start_idle, restart, load, clear;
   logic [WORD_W-1:0] load_data;
   logic [WORD_W-1:0] rx_word;
   logic [WORD_W-1:0] rxbuf;
   logic [WORD_W-1:0] pend_data;
   logic              pend, q_write, use_pend;
   logic              rx_full, ovr;
   logic              sdo_bit;

   assign wr_ctl  = wr_en && (addr == REG_CTRL);
   assign wr_stat = wr_en && (addr == REG_STAT);
   assign wr_tx   = wr_en && (addr == REG_TXB);
   assign rd_rx   = rd_en && (addr == REG_RXB);
   assign clear   = !ctrl.pwr;

   csio_ctrl_reg u_ctrl (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (wr_ctl),
      .wval (csio_ctrl_t'(wdata[CTRL_W-1:0])),
      .ctrl (ctrl)
   );

   // start from idle: transmit-buffer write, or receive-buffer read when receive-only
   assign start_idle = ctrl.pwr && !busy &&
                       ((wr_tx && ctrl.tx_en) ||
                        (rd_rx && !ctrl.tx_en && ctrl.rx_en));

   // seamless follow-on word in continuous mode
   assign restart  = done && ctrl.cont &&
                     (ctrl.tx_en ? (pend || wr_tx) : ctrl.rx_en);
   assign use_pend = restart && pend;
   assign load     = start_idle || restart;

   assign load_data = !ctrl.tx_en ? '1 :
                      use_pend    ? pend_data : wdata;

   // queue a word written mid-transfer, unless it is consumed directly at done
   assign q_write = wr_tx && ctrl.cont && ctrl.tx_en && busy && !(done && !pend);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         pend      <= 1'b0;
         pend_data <= '0;
      end else begin
         if (use_pend) begin
            pend <= 1'b0;
         end
         if (q_write) begin
            pend      <= 1'b1;
            pend_data <= wdata;
         end
      end
   end

   csio_bit_timer #(
      .WORD_W (WORD_W),
      .CLK_DIV(CLK_DIV)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .load      (load),
      .busy      (busy),
      .sclk      (sclk),
      .sample_stb(sample_stb),
      .shift_stb (shift_stb),
      .done      (done)
   );

   csio_shifter #(
      .WORD_W(WORD_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .load      (load),
      .load_data (load_data),
      .lsb_first (ctrl.lsb_first),
      .shift_stb (shift_stb),
      .sample_stb(sample_stb),
      .sdi       (sdi),
      .sdo_bit   (sdo_bit),
      .rx_word   (rx_word)
   );

   assign sdo = (busy && ctrl.tx_en) ? sdo_bit : 1'b1;

   // receive buffer and overrun flag
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rxbuf   <= '0;
         rx_full <= 1'b0;
         ovr     <= 1'b0;
      end else begin
         if (wr_stat && wdata[STAT_OVR]) begin
            ovr <= 1'b0;
         end
         if (done && ctrl.rx_en) begin
            rxbuf   <= rx_word;
            rx_full <= 1'b1;
            if (rx_full && !rd_rx) begin
               ovr <= 1'b1;
            end
         end else if (rd_rx) begin
            rx_full <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_tx <= 1'b0;
         irq_rx <= 1'b0;
      end else begin
         irq_tx <= load && ctrl.cont && ctrl.tx_en && ctrl.pwr;
         irq_rx <= done;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         REG_CTRL: rdata[CTRL_W-1:0] = ctrl;
         REG_STAT: begin
            rdata[STAT_BUSY] = busy;
            rdata[STAT_OVR]  = ovr;
         end
         REG_RXB:  rdata = rxbuf;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/csio_checker.sv
module csio_checker #(
   parameter int WORD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [WORD_W-1:0] wdata,
   input logic              sclk,
   input logic              irq_tx,
   input logic              irq_rx,
   input logic              busy,
   input logic              ovr,
   input logic              ctrl_pwr,
   input logic              ctrl_cont,
   input logic              ctrl_lsb
);

   a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sclk);

   a_r2_frame_locked: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_pwr |=> ($stable(ctrl_cont) && $stable(ctrl_lsb)));

   a_r6_single_no_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_cont |-> !irq_tx);

   a_r6_done_pulses_rx: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(ctrl_pwr)) |-> irq_rx);

   a_r9_tx_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |=> !irq_tx);

   a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !(wr_en && addr == 2'd1 && wdata[1])) |=> ovr);

   a_r12_power_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_pwr |=> !busy);

endmodule

bind csio_top csio_checker #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .sclk     (sclk),
   .irq_tx   (irq_tx),
   .irq_rx   (irq_rx),
   .busy     (busy),
   .ovr      (ovr),
   .ctrl_pwr (ctrl.pwr),
   .ctrl_cont(ctrl.cont),
   .ctrl_lsb (ctrl.lsb_first)
);

// File: tb/sim_csio_top.sv
module sim_csio_top;

   localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_TXB = 2'd2, A_RXB = 2'd3;
   localparam logic [7:0] P = 8'h01, T = 8'h02, R = 8'h04, C = 8'h08, L = 8'h10;

   // {direction, transmit word, slave word}
   localparam logic [16:0] VEC [0:5] = '{
      17'h0A53C, 17'h1817E, 17'h000FF, 17'h1C301, 17'h0FF80, 17'h15AE7
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, sdi = 1'b1;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00, rdata;
   logic       sclk, sdo, irq_tx, irq_rx;

   always #4 clk = ~clk;

   csio_top #(.WORD_W(8), .CLK_DIV(4), .ADDR_W(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .sclk(sclk), .sdo(sdo), .sdi(sdi),
      .irq_tx(irq_tx), .irq_rx(irq_rx)
   );

   int         n_chk = 0, n_bad = 0;
   bit         finished = 0;
   int         n_txi = 0, n_rxi = 0, n_rise = 0, s_idx = 0;
   logic [7:0] slave = 8'h00;
   bit         lsb_mode = 0;
   logic [15:0] cap = 16'h0;

   always @(negedge clk) begin
      if (irq_tx === 1'b1) n_txi++;
      if (irq_rx === 1'b1) n_rxi++;
   end

   // serial slave: new bit on each falling edge, capture data out on rising edge
   always @(negedge sclk) begin
      sdi = lsb_mode ? slave[s_idx] : slave[7 - s_idx];
      s_idx = (s_idx + 1) % 8;
   end
   always @(posedge sclk) begin
      cap = {cap[14:0], sdo};
      n_rise++;
   end

   function automatic logic [7:0] rev8(input logic [7:0] v);
      for (int i = 0; i < 8; i++) rev8[i] = v[7 - i];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      addr = A_STAT;
      #1;
      while (rdata[0] === 1'b1 && cyc < 2000) begin
         cyc++;
         @(negedge clk);
         #1;
      end
   endtask

   task automatic setup(input logic [7:0] ctl, input logic [7:0] sw);
      wr(A_CTRL, 8'h00);
      wr(A_CTRL, ctl);
      lsb_mode = ctl[4];
      slave = sw;
      s_idx = 0;
      cap = 16'h0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      logic [7:0] v;
      int c, rx0, tx0, r0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek(A_CTRL, v); check("R1 ctrl", v, 8'h00);
      peek(A_STAT, v); check("R1 status", v, 8'h00);
      check("R1 sclk", sclk, 1'b1);
      check("R1 sdo", sdo, 1'b1);
      check("R1 irq", {irq_tx, irq_rx}, 2'b00);

      // single-mode full-duplex table (R3 R4 R5 R6)
      for (int i = 0; i < 6; i++) begin
         logic [16:0] e;
         e = VEC[i];
         setup(P | T | R | (e[16] ? L : 8'h00), e[7:0]);
         rx0 = n_rxi; tx0 = n_txi; r0 = n_rise;
         wr(A_TXB, e[15:8]);
         wait_idle(c);
         check("R3 busy length", c, 32);
         check("R3 rising edges", n_rise - r0, 8);
         rd(A_RXB, v);
         check(e[16] ? "R5 rx word" : "R4 rx word", v, e[7:0]);
         check(e[16] ? "R5 tx word" : "R4 tx word", cap[7:0],
               e[16] ? rev8(e[15:8]) : e[15:8]);
         check("R6 rx pulse", n_rxi - rx0, 1);
         check("R6 no tx pulse", n_txi - tx0, 0);
      end

      // R2 framing bits locked while powered
      wr(A_CTRL, 8'h00);
      wr(A_CTRL, P);
      wr(A_CTRL, P | C | L);
      @(negedge clk); peek(A_CTRL, v); check("R2 locked", v, P);
      wr(A_CTRL, 8'h00);
      wr(A_CTRL, P | C | L);
      @(negedge clk); peek(A_CTRL, v); check("R2 set with power", v, P | C | L);

      // R7 single mode discards write while busy
      setup(P | T | R, 8'h00);
      r0 = n_rise;
      wr(A_TXB, 8'h96);
      repeat (5) @(negedge clk);
      wr(A_TXB, 8'h11);
      wait_idle(c);
      check("R7 busy ends after one word", c, 25);
      repeat (40) @(negedge clk);
      peek(A_STAT, v); check("R7 stays idle", v[0], 1'b0);
      check("R7 one word sent", cap, 16'h0096);
      check("R7 edges", n_rise - r0, 8);

      // R8 single receive-only starts on read
      setup(P | R, 8'hB4);
      rx0 = n_rxi;
      rd(A_RXB, v);
      peek(A_STAT, v); check("R8 read starts", v[0], 1'b1);
      repeat (6) @(negedge clk);
      rd(A_RXB, v);
      wait_idle(c);
      repeat (40) @(negedge clk);
      peek(A_STAT, v); check("R8 no restart", v[0], 1'b0);
      check("R8 one word", n_rxi - rx0, 1);
      peek(A_RXB, v); check("R8 rx word", v, 8'hB4);

      // R9 continuous transmit queue
      setup(P | T | R | C, 8'h99);
      tx0 = n_txi;
      wr(A_TXB, 8'h3C);
      repeat (5) @(negedge clk);
      check("R9 tx pulse on load", n_txi - tx0, 1);
      wr(A_TXB, 8'hC5);
      wait_idle(c);
      check("R9 no gap", c, 57);
      check("R9 two words", cap, 16'h3CC5);
      check("R9 tx pulses", n_txi - tx0, 2);
      peek(A_STAT, v); check("R11 ovr after unread", v[1], 1'b1);
      wr(A_STAT, 8'h02);
      @(negedge clk); peek(A_STAT, v); check("R11 cleared", v[1], 1'b0);

      // R10 continuous receive-only auto restart, R11 overrun, R12 power-off
      setup(P | R | C, 8'h42);
      rx0 = n_rxi;
      rd(A_RXB, v);
      c = 0;
      while (n_rxi - rx0 < 3 && c < 1000) begin
         @(negedge clk);
         c++;
      end
      check("R10 three words", n_rxi - rx0, 3);
      peek(A_STAT, v); check("R10 still running", v[0], 1'b1);
      check("R11 overrun", v[1], 1'b1);
      peek(A_RXB, v); check("R10 rx word", v, 8'h42);
      wr(A_CTRL, R | C);
      @(negedge clk);
      peek(A_STAT, v); check("R12 idle", v[0], 1'b0);
      check("R11 ovr kept", v[1], 1'b1);
      check("R12 sclk high", sclk, 1'b1);
      peek(A_CTRL, v); check("R12 ctrl kept", v, R | C);
      wr(A_STAT, 8'h02);
      @(negedge clk); peek(A_STAT, v); check("R11 clear", v, 8'h00);

      finish_up();
   end

endmodule